// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds the current time of day and calendar date as eight packed-BCD byte registers and moves them forward by one second on every pulse of a one-second tick input. Seconds carry into minutes, minutes into hours, hours into the day of month and the weekday, days into the month, months into the two-digit year, and the year into a separate century byte. The last day of each month is worked out from the stored month and year, so February gets 28 or 29 days.

A host sets the clock through a parallel load port. One load can write either the whole bank or only the seconds, minutes and hours bytes. The eight bytes are always readable on a registered parallel output. A clock-failure flag comes up at reset to tell the host that the time is not trustworthy. The first load of any kind clears it.

Top module: `bcd_calendar`

## Requirements
- R1: After a synchronous reset, the bank holds seconds 0x00, minutes 0x00, hours 0x80, day 0x01, month 0x01, year 0x00, weekday 0x00 and century 0x20, and `clk_fail` is 1.
- R2: `cal_q` presents byte k on bits [8k+7:8k], in this order for k = 0..7: seconds, minutes, hours, day of month, month, year, weekday, century. `load_data` uses the same layout.
- R3: A tick with no load increments seconds in BCD. Seconds 0x59 wrap to 0x00 and carry into minutes, and minutes 0x59 wrap to 0x00 and carry into hours.
- R4: Bits [5:0] of the hours byte count in BCD from 0x00 to 0x23. At 0x23, a carry wraps them to 0x00 and carries into the day. Counting never changes bits [7:6], and bit 7 is the 24-hour flag.
- R5: The day wraps to 0x01 and carries into the month after day 0x30 for months 0x04, 0x06, 0x09 and 0x11, and after day 0x31 for every other month except February.
- R6: In February the last day is 0x29 when the BCD year is divisible by 4 (0x00 counts as divisible) and 0x28 otherwise.
- R7: Each day carry increments the weekday, a binary value from 0 to 6, and 6 wraps to 0. The weekday does not change without a day carry.
- R8: Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00 and increments the century in BCD (0x19 becomes 0x20).
- R9: A load with `load_date` = 1 writes all eight bytes from `load_data`, and the bytes appear on `cal_q` in the next cycle.
- R10: A load with `load_date` = 0 writes only bytes 0 to 2. Bytes 3 to 7 keep their values.
- R11: When `load_en` and `tick` are high in the same cycle, the loaded value is stored and that tick is not counted.
- R12: `clk_fail` is set by reset, cleared by any load, and otherwise keeps its value.
- R13: With neither `tick` nor `load_en` high, the bank does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| load_en | input | 1 | Load strobe |
| load_date | input | 1 | 1: load all eight bytes; 0: load time bytes only |
| load_data | input | 64 | Bytes to load, same layout as `cal_q` |
| cal_q | output | 64 | Registered calendar bank |
| clk_fail | output | 1 | Time-invalid flag |

## Verification
The bench goes after every carry boundary. It checks the ends of 30-day and 31-day months, February in leap and common years (including year 00, and year 12 to catch an odd-tens digit), December 31 into a new year, and 1999 into 2000. A design with a wrong leap rule or month table lands on a day 29, 30 or 31 that does not exist, or skips one that does. A BCD incrementer that ignores the nibble boundary produces 0x0A instead of 0x10. The bench also sets the hour flag on both sides of a wrap, so that counting that corrupts bit 7 shows up. It tests a load and a tick in the same cycle, where a design with the wrong priority shows the loaded value advanced by one second. It tests a time-only load, where a design that ignores the mode overwrites the date.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 8;
  localparam int CAL_W     = BYTE_W * NUM_BYTES;

  // Byte positions in the bank (the ordering is part of the interface)
  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HOUR = 2;
  localparam int IX_DAY  = 3;
  localparam int IX_MON  = 4;
  localparam int IX_YEAR = 5;
  localparam int IX_WDAY = 6;
  localparam int IX_CENT = 7;
  localparam int NUM_CHAIN = 6;  // seconds .. year form the carry chain

  // Next packed-BCD value, no range limit.
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisible-by-4 test on a packed-BCD year.
  function automatic logic bcd_div4(input logic [BYTE_W-1:0] y);
    logic u_ok_even, u_ok_odd;
    u_ok_even = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    u_ok_odd  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? u_ok_odd : u_ok_even;
  endfunction
endpackage

// File: rtl/bcd_field.sv
module bcd_field
  import cal_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] wrap,
  input  logic         carry_in,
  output logic [W-1:0] nxt,
  output logic         carry_out
);
  logic at_limit;

  always_comb begin
    at_limit  = (cur == limit);
    carry_out = carry_in && at_limit;
    if (!carry_in)     nxt = cur;
    else if (at_limit) nxt = wrap;
    else               nxt = bcd_inc(cur);
  end
endmodule

// File: rtl/cal_month_end.sv
module cal_month_end
  import cal_pkg::*;
(
  input  logic [BYTE_W-1:0] month,
  input  logic [BYTE_W-1:0] year,
  output logic [BYTE_W-1:0] last_day
);
  always_comb begin
    unique case (month)
      8'h02:                      last_day = bcd_div4(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int                TIME_BYTES  = 3,
  parameter logic [BYTE_W-1:0] RST_HOUR    = 8'h80,
  parameter logic [BYTE_W-1:0] RST_CENTURY = 8'h20,
  parameter int                WDAY_W      = 3,
  parameter int                WDAY_LAST   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic             load_date,
  input  logic [CAL_W-1:0] load_data,
  output logic [CAL_W-1:0] cal_q,
  output logic             clk_fail
);
  localparam logic [BYTE_W-1:0] HOUR_VAL_MASK  = 8'h3F;
  localparam logic [BYTE_W-1:0] HOUR_FLAG_MASK = ~HOUR_VAL_MASK;

  logic [BYTE_W-1:0] bank [NUM_BYTES];
  logic [BYTE_W-1:0] fcur [NUM_CHAIN];
  logic [BYTE_W-1:0] flim [NUM_CHAIN];
  logic [BYTE_W-1:0] fwrap[NUM_CHAIN];
  logic [BYTE_W-1:0] fnxt [NUM_CHAIN];
  logic              fcar [NUM_CHAIN+1];
  logic [BYTE_W-1:0] day_last, cent_nxt;
  logic              cent_car;
  logic [WDAY_W-1:0] wday_nxt;

  cal_month_end u_mend (
    .month(bank[IX_MON]), .year(bank[IX_YEAR]), .last_day(day_last)
  );

  always_comb begin
    fcur[IX_SEC]  = bank[IX_SEC];   flim[IX_SEC]  = 8'h59;  fwrap[IX_SEC]  = 8'h00;
    fcur[IX_MIN]  = bank[IX_MIN];   flim[IX_MIN]  = 8'h59;  fwrap[IX_MIN]  = 8'h00;
    fcur[IX_HOUR] = bank[IX_HOUR] & HOUR_VAL_MASK;
    flim[IX_HOUR] = 8'h23;          fwrap[IX_HOUR] = 8'h00;
    fcur[IX_DAY]  = bank[IX_DAY];   flim[IX_DAY]  = day_last; fwrap[IX_DAY] = 8'h01;
    fcur[IX_MON]  = bank[IX_MON];   flim[IX_MON]  = 8'h12;  fwrap[IX_MON]  = 8'h01;
    fcur[IX_YEAR] = bank[IX_YEAR];  flim[IX_YEAR] = 8'h99;  fwrap[IX_YEAR] = 8'h00;
    fcar[0] = tick;
  end

  for (genvar i = 0; i < NUM_CHAIN; i++) begin : g_chain
    bcd_field #(.W(BYTE_W)) u_fld (
      .cur(fcur[i]), .limit(flim[i]), .wrap(fwrap[i]),
      .carry_in(fcar[i]), .nxt(fnxt[i]), .carry_out(fcar[i+1])
    );
  end

  bcd_field #(.W(BYTE_W)) u_cent (
    .cur(bank[IX_CENT]), .limit(8'h99), .wrap(8'h00),
    .carry_in(fcar[NUM_CHAIN]), .nxt(cent_nxt), .carry_out(cent_car)
  );

  always_comb begin
    if (bank[IX_WDAY][WDAY_W-1:0] >= WDAY_W'(WDAY_LAST)) wday_nxt = '0;
    else wday_nxt = bank[IX_WDAY][WDAY_W-1:0] + WDAY_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank[IX_SEC]  <= 8'h00;
      bank[IX_MIN]  <= 8'h00;
      bank[IX_HOUR] <= RST_HOUR;
      bank[IX_DAY]  <= 8'h01;
      bank[IX_MON]  <= 8'h01;
      bank[IX_YEAR] <= 8'h00;
      bank[IX_WDAY] <= 8'h00;
      bank[IX_CENT] <= RST_CENTURY;
      clk_fail      <= 1'b1;
    end else if (load_en) begin
      for (int k = 0; k < NUM_BYTES; k++)
        if (load_date || k < TIME_BYTES) bank[k] <= load_data[k*BYTE_W +: BYTE_W];
      clk_fail <= 1'b0;
    end else if (tick) begin
      bank[IX_SEC]  <= fnxt[IX_SEC];
      bank[IX_MIN]  <= fnxt[IX_MIN];
      bank[IX_HOUR] <= fnxt[IX_HOUR] | (bank[IX_HOUR] & HOUR_FLAG_MASK);
      bank[IX_DAY]  <= fnxt[IX_DAY];
      bank[IX_MON]  <= fnxt[IX_MON];
      bank[IX_YEAR] <= fnxt[IX_YEAR];
      if (fcar[IX_DAY]) bank[IX_WDAY] <= {{(BYTE_W-WDAY_W){1'b0}}, wday_nxt};
      bank[IX_CENT] <= cent_nxt;
    end
  end

  always_comb
    for (int k = 0; k < NUM_BYTES; k++) cal_q[k*BYTE_W +: BYTE_W] = bank[k];

  // Seconds at 59 roll over and bump minutes (R3)
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    tick && !load_en && bank[IX_SEC] == 8'h59 && bank[IX_MIN] != 8'h59
    |=> bank[IX_SEC] == 8'h00 && bank[IX_MIN] == bcd_inc($past(bank[IX_MIN])));

  // Counting leaves the flag bits of the hour byte alone (R4)
  p_hour_flag_r4: assert property (@(posedge clk) disable iff (rst)
    tick && !load_en |=> bank[IX_HOUR][7:6] == $past(bank[IX_HOUR][7:6]));

  // Weekday moves only on a day carry (R7)
  p_wday_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load_en && !fcar[IX_DAY] |=> bank[IX_WDAY] == $past(bank[IX_WDAY]));

  // Time-only load keeps the date bytes (R10)
  p_time_only_r10: assert property (@(posedge clk) disable iff (rst)
    load_en && !load_date |=> cal_q[CAL_W-1:TIME_BYTES*BYTE_W] ==
                               $past(cal_q[CAL_W-1:TIME_BYTES*BYTE_W]));

  // Load wins over a tick in the same cycle (R11)
  p_load_prio_r11: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cal_q[TIME_BYTES*BYTE_W-1:0] == $past(load_data[TIME_BYTES*BYTE_W-1:0]));

  // Failure flag: cleared by load, falls only on a load (R12)
  p_fail_clear_r12: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !clk_fail);
  p_fail_fall_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_fail) |-> $past(load_en));

  // Idle cycles hold the bank (R13)
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !tick && !load_en |=> $stable(cal_q));
endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;
  localparam int  NVEC       = 19;

  // Each entry: {loaded bank, bank after one tick}
  // byte order high->low: century, weekday, year, month, day, hour, min, sec
  localparam logic [127:0] VEC [NVEC] = '{
    {64'h20_03_24_05_15_80_10_08, 64'h20_03_24_05_15_80_10_09}, // R3
    {64'h20_03_24_05_15_80_10_09, 64'h20_03_24_05_15_80_10_10}, // R3 nibble carry
    {64'h20_03_24_05_15_80_10_59, 64'h20_03_24_05_15_80_11_00}, // R3
    {64'h20_03_24_05_15_80_59_59, 64'h20_03_24_05_15_81_00_00}, // R3 into hour
    {64'h20_03_24_05_15_89_59_59, 64'h20_03_24_05_15_90_00_00}, // R4 flag kept
    {64'h20_03_24_05_15_A3_59_59, 64'h20_04_24_05_16_80_00_00}, // R4 R7
    {64'h20_06_24_05_15_23_59_59, 64'h20_00_24_05_16_00_00_00}, // R4 R7 wrap 6->0
    {64'h20_01_24_04_30_A3_59_59, 64'h20_02_24_05_01_80_00_00}, // R5 April
    {64'h20_01_24_01_31_A3_59_59, 64'h20_02_24_02_01_80_00_00}, // R5 January
    {64'h20_01_24_05_30_A3_59_59, 64'h20_02_24_05_31_80_00_00}, // R5 May
    {64'h20_01_24_11_30_A3_59_59, 64'h20_02_24_12_01_80_00_00}, // R5 November
    {64'h20_01_24_02_28_A3_59_59, 64'h20_02_24_02_29_80_00_00}, // R6 leap
    {64'h20_01_23_02_28_A3_59_59, 64'h20_02_23_03_01_80_00_00}, // R6 common
    {64'h20_01_24_02_29_A3_59_59, 64'h20_02_24_03_01_80_00_00}, // R6 leap end
    {64'h20_01_12_02_28_A3_59_59, 64'h20_02_12_02_29_80_00_00}, // R6 odd tens
    {64'h20_01_10_02_28_A3_59_59, 64'h20_02_10_03_01_80_00_00}, // R6 year 10
    {64'h20_01_24_12_31_A3_59_59, 64'h20_02_25_01_01_80_00_00}, // R8 new year
    {64'h19_05_99_12_31_A3_59_59, 64'h20_06_00_01_01_80_00_00}, // R8 century
    {64'h20_01_00_02_28_A3_59_59, 64'h20_02_00_02_29_80_00_00}  // R6 year 00
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        load_en = 1'b0;
  logic        load_date = 1'b0;
  logic [63:0] load_data = '0;
  logic [63:0] cal_q;
  logic        clk_fail;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bcd_calendar uut (
    .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
    .load_date(load_date), .load_data(load_data),
    .cal_q(cal_q), .clk_fail(clk_fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] d, input logic full);
    @(negedge clk);
    load_en = 1'b1; load_date = full; load_data = d;
    @(negedge clk);
    load_en = 1'b0; load_date = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset values, R2 byte layout
    check("R1 reset bank", cal_q, 64'h20_00_00_01_01_80_00_00);
    check("R1 R12 clk_fail after reset", {63'd0, clk_fail}, 64'd1);
    check("R2 hour byte at bits 23:16", {56'd0, cal_q[23:16]}, 64'h80);
    // R13 idle hold
    repeat (5) @(negedge clk);
    check("R13 idle hold", cal_q, 64'h20_00_00_01_01_80_00_00);
    // R10 time-only load as first write, R12 flag clears
    do_load(64'hFF_FF_FF_FF_FF_12_34_56, 1'b0);
    check("R10 time-only load", cal_q, 64'h20_00_00_01_01_12_34_56);
    check("R12 clk_fail cleared", {63'd0, clk_fail}, 64'd0);

    // Table walk: R9 on each load, R3..R8 on each tick
    for (int i = 0; i < NVEC; i++) begin
      do_load(VEC[i][127:64], 1'b1);
      check($sformatf("R9 full load vec %0d", i), cal_q, VEC[i][127:64]);
      do_tick();
      check($sformatf("R3 R4 R5 R6 R7 R8 tick vec %0d", i), cal_q, VEC[i][63:0]);
    end
    check("R12 flag stays clear", {63'd0, clk_fail}, 64'd0);

    // R11 load and tick together: no advance
    @(negedge clk);
    load_en = 1'b1; load_date = 1'b1; tick = 1'b1;
    load_data = 64'h20_01_24_05_15_80_10_08;
    @(negedge clk);
    load_en = 1'b0; load_date = 1'b0; tick = 1'b0;
    check("R11 load beats tick", cal_q, 64'h20_01_24_05_15_80_10_08);

    // R10 time-only load after a full date keeps date
    do_load(64'h19_05_99_12_31_A3_59_59, 1'b0);
    check("R10 date kept", cal_q, 64'h20_01_24_05_15_A3_59_59);

    // R12 reset sets the flag again
    do_reset();
    check("R12 flag set by reset", {63'd0, clk_fail}, 64'd1);
    check("R1 bank after second reset", cal_q, 64'h20_00_00_01_01_80_00_00);
    finish_run();
  end
endmodule